// File: doc/BRIEF.md
# PHY Management Address and Isolate Control

This block is the management-facing front end of a PHY. While reset is held it samples a 5-bit station address from strap pins and keeps it until the next reset. A parallel management request carries a target PHY address, a register index, a read/write flag and write data. The block decides whether the request is meant for this PHY: it matches its own strapped address and also the all-zero address. It serves a small basic control register and a read-only address/status register.

Requests use a valid/ready handshake, and so do responses. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Every accepted request, write or read, produces exactly one response. The response stays registered until the consumer raises `rsp_ready`. Only one response is held, so `req_ready` drops whenever a response is waiting and `rsp_ready` is low. That is the only source of back-pressure.

The isolate state leaves the block as a plain output, for the data path to disconnect from the MAC side. A strapped address of zero keeps the PHY isolated.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: While `rst_n` is low the strap value is captured on every clock edge. After reset it is held unchanged. Register 25 reads as {9'b0, speed_10, conn_ok, address[4:0]}: address in bits 4:0, `conn_ok` in bit 5, `speed_10` in bit 6.
- R2: A request hits when `req_phy` equals the strapped address or 5'b00000. A request with any other PHY address returns `rsp_hit`=0 and data 0, and a write to it changes no state.
- R3: With a strapped address of zero, control bit 10 reads 1 and `isolate` is 1, whatever is written.
- R4: Register 0 is the control register: bit 15 reset, bit 12 auto-negotiation enable, bit 10 isolate, bit 9 restart auto-negotiation, bit 8 full duplex. All other bits read 0. After reset, bit 12 is 1 and the rest are 0 (bit 10 follows R3).
- R5: Bits 15 and 9 are self-clearing. A read accepted on the edge right after the write returns 1, and any later read returns 0.
- R6: A write with bit 15 set restores bits 12, 10 and 8 to their defaults and ignores the other data bits of that write. It does not resample the straps.
- R7: Every register other than 0 and 25 reads 0, and writes to them have no effect. Register 25 is read-only.
- R8: `req_ready` = !`rsp_valid` || `rsp_ready`. Each accepted request produces one response, which holds its data and hit flag until `rsp_ready` is high. Write responses carry data 0.
- R9: `isolate` always equals control bit 10 as it would read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps sampled while low |
| strap_addr | input | 5 | Address strap pins |
| conn_ok | input | 1 | Connection status reported in register 25 bit 5 |
| speed_10 | input | 1 | 10 Mb/s indication reported in register 25 bit 6 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Register index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_hit | output | 1 | Request addressed this PHY |
| rsp_rdata | output | 16 | Read data (0 for writes and misses) |
| isolate | output | 1 | PHY isolated from the MAC side |

## Verification
The hardest case to reach from the ports is the one-cycle window in which the self-clearing reset and restart bits are visible. The stimulus gets there by issuing a control write and a control read on consecutive edges while `rsp_ready` stays high, then a second read to see the bit gone. The bench also reaches a stalled response, with a further request parked on the input, by dropping `rsp_ready`. The straps can only change through reset, so the run goes through several resets with different strap values, including zero.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int PHY_AW   = 5;
  localparam int REG_AW   = 5;
  localparam int DATA_W   = 16;
  localparam int CTRL_IDX = 0;
  localparam int STAT_IDX = 25;

  // control register bit positions
  localparam int B_RST  = 15;
  localparam int B_ANE  = 12;
  localparam int B_ISO  = 10;
  localparam int B_RSAN = 9;
  localparam int B_FDX  = 8;

  localparam logic ANE_DEFAULT = 1'b1;

  typedef struct packed {
    logic rst;
    logic ane;
    logic iso;
    logic rsan;
    logic fdx;
  } ctrl_bits_t;
endpackage

// File: rtl/phy_strap_latch.sv
module phy_strap_latch #(
  parameter int AW = phy_mgmt_pkg::PHY_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] strap,
  output logic [AW-1:0] addr,
  output logic          addr_zero
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= strap;
  end

  assign addr      = addr_q;
  assign addr_zero = (addr_q == '0);

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(addr_q)); // R1
endmodule

// File: rtl/phy_addr_match.sv
module phy_addr_match #(
  parameter int AW          = phy_mgmt_pkg::PHY_AW,
  parameter bit ANSWER_ZERO = 1'b1
) (
  input  logic [AW-1:0] own_addr,
  input  logic [AW-1:0] req_addr,
  output logic          hit
);
  logic own_hit;
  assign own_hit = (req_addr == own_addr);

  generate
    if (ANSWER_ZERO) begin : g_with_zero
      assign hit = own_hit || (req_addr == '0);
    end else begin : g_own_only
      assign hit = own_hit;
    end
  endgenerate
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_mgmt_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          force_iso,
  output logic [DW-1:0] rd_value,
  output logic          isolate
);
  ctrl_bits_t c_q;
  logic       iso_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q.rst  <= 1'b0;
      c_q.ane  <= ANE_DEFAULT;
      c_q.iso  <= 1'b0;
      c_q.rsan <= 1'b0;
      c_q.fdx  <= 1'b0;
    end else begin
      c_q.rst  <= 1'b0;
      c_q.rsan <= 1'b0;
      if (wr_en) begin
        if (wdata[B_RST]) begin
          c_q.rst <= 1'b1;
          c_q.ane <= ANE_DEFAULT;
          c_q.iso <= 1'b0;
          c_q.fdx <= 1'b0;
        end else begin
          c_q.ane  <= wdata[B_ANE];
          c_q.iso  <= wdata[B_ISO];
          c_q.fdx  <= wdata[B_FDX];
          c_q.rsan <= wdata[B_RSAN];
        end
      end
    end
  end

  assign iso_eff = c_q.iso | force_iso;

  always_comb begin
    rd_value         = '0;
    rd_value[B_RST]  = c_q.rst;
    rd_value[B_ANE]  = c_q.ane;
    rd_value[B_ISO]  = iso_eff;
    rd_value[B_RSAN] = c_q.rsan;
    rd_value[B_FDX]  = c_q.fdx;
  end

  assign isolate = iso_eff;

  logic unused_bits;
  assign unused_bits = &{1'b0, wdata};

  AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (c_q.rst || c_q.rsan) && !wr_en |=> !c_q.rst && !c_q.rsan); // R5
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(c_q.ane) && $stable(c_q.iso) && $stable(c_q.fdx)); // R2
endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int AW       = PHY_AW,
  parameter int RW       = REG_AW,
  parameter int DW       = DATA_W,
  parameter int CTRL_REG = CTRL_IDX,
  parameter int STAT_REG = STAT_IDX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] strap_addr,
  input  logic          conn_ok,
  input  logic          speed_10,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_phy,
  input  logic [RW-1:0] req_reg,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_hit,
  output logic [DW-1:0] rsp_rdata,
  output logic          isolate
);
  localparam int PAD_W = DW - AW - 2;

  logic [AW-1:0] own_addr;
  logic          own_zero;
  logic          hit;
  logic          accept;
  logic          is_ctrl, is_stat;
  logic          ctrl_wr;
  logic [DW-1:0] ctrl_value;
  logic [DW-1:0] stat_value;
  logic [DW-1:0] rd_mux;

  logic          rsp_valid_q, rsp_hit_q, rsp_ctrl_q;
  logic [DW-1:0] rsp_data_q;

  phy_strap_latch #(.AW(AW)) u_strap (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap     (strap_addr),
    .addr      (own_addr),
    .addr_zero (own_zero)
  );

  phy_addr_match #(.AW(AW), .ANSWER_ZERO(1'b1)) u_match (
    .own_addr (own_addr),
    .req_addr (req_phy),
    .hit      (hit)
  );

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign is_ctrl   = (req_reg == RW'(CTRL_REG));
  assign is_stat   = (req_reg == RW'(STAT_REG));
  assign ctrl_wr   = accept && hit && req_write && is_ctrl;

  phy_ctrl_reg #(.DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctrl_wr),
    .wdata     (req_wdata),
    .force_iso (own_zero),
    .rd_value  (ctrl_value),
    .isolate   (isolate)
  );

  assign stat_value = {{PAD_W{1'b0}}, speed_10, conn_ok, own_addr};

  always_comb begin
    rd_mux = '0;
    if (hit && !req_write) begin
      if (is_ctrl)      rd_mux = ctrl_value;
      else if (is_stat) rd_mux = stat_value;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_ctrl_q  <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_hit_q   <= hit;
      rsp_ctrl_q  <= hit && !req_write && is_ctrl;
      rsp_data_q  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_rdata = rsp_data_q;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_hit)); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_rdata == '0); // R2
  AST_ZERO_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ctrl_q && own_zero |-> rsp_rdata[B_ISO]); // R3
endmodule

// File: tb/test_phy_mgmt_ctrl.sv
module test_phy_mgmt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  strap_addr = '0;
  logic        conn_ok = 1'b0, speed_10 = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [4:0]  req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid, rsp_hit, isolate;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [4:0] m_addr;
  logic m_ane, m_iso, m_fdx, m_rst, m_rs;
  logic pend;
  logic p_hit;
  logic [15:0] p_data;
  string p_tag;

  phy_mgmt_ctrl i_phy_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .conn_ok(conn_ok),
    .speed_10(speed_10), .req_valid(req_valid), .req_ready(req_ready),
    .req_phy(req_phy), .req_reg(req_reg), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata), .isolate(isolate)
  );

  always #2 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic iso_view();
    return m_iso | (m_addr == 5'd0);
  endfunction

  function automatic logic [15:0] exp_read(logic [4:0] rg, logic cn, logic sp);
    if (rg == 5'd0)  return {m_rst, 2'b00, m_ane, 1'b0, iso_view(), m_rs, m_fdx, 8'h00};
    if (rg == 5'd25) return {9'h000, sp, cn, m_addr};
    return 16'h0000;
  endfunction

  task automatic do_reset(logic [4:0] s);
    @(negedge clk);
    rst_n = 1'b0; strap_addr = s; req_valid = 1'b0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    strap_addr = ~s;   // straps change after reset: must be ignored (R1)
    m_addr = s; m_ane = 1'b1; m_iso = 1'b0; m_fdx = 1'b0; m_rst = 1'b0; m_rs = 1'b0;
    pend = 1'b0;
    chk("R8 reset rsp_valid", rsp_valid, 0);
    chk("R8 reset req_ready", req_ready, 1);
    chk(s == 0 ? "R3 reset isolate" : "R4 reset isolate", isolate, (s == 0));
  endtask

  // called right after a falling edge; returns after the next falling edge
  task automatic step(bit v, logic [4:0] phy, logic [4:0] rg, bit wr,
                      logic [15:0] wd, bit cn, bit sp, string tag);
    logic h;
    chk(m_addr == 0 ? "R3 isolate" : "R9 isolate", isolate, iso_view());
    if (pend) begin
      chk({p_tag, " rsp_valid"}, rsp_valid, 1);
      chk({p_tag, " rsp_hit"}, rsp_hit, p_hit);
      chk({p_tag, " data"}, rsp_rdata, p_data);
    end else begin
      chk("R8 idle rsp_valid", rsp_valid, 0);
    end
    req_valid = v; req_phy = phy; req_reg = rg; req_write = wr; req_wdata = wd;
    conn_ok = cn; speed_10 = sp;
    h = (phy == m_addr) || (phy == 5'd0);
    pend   = v;
    p_hit  = h;
    p_data = (h && !wr) ? exp_read(rg, cn, sp) : 16'h0000;
    if (tag != "")     p_tag = tag;
    else if (!h)       p_tag = "R2";
    else if (rg == 0)  p_tag = "R4";
    else if (rg == 25) p_tag = "R1";
    else               p_tag = "R7";
    m_rst = 1'b0; m_rs = 1'b0;
    if (v && wr && h && rg == 5'd0) begin
      if (wd[15]) begin
        m_rst = 1'b1; m_ane = 1'b1; m_iso = 1'b0; m_fdx = 1'b0;
      end else begin
        m_ane = wd[12]; m_iso = wd[10]; m_fdx = wd[8]; m_rs = wd[9];
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rand_run(int n);
    for (int i = 0; i < n; i++) begin
      logic [4:0] phy, rg;
      int pick;
      pick = $urandom_range(0, 9);
      phy = (pick < 4) ? m_addr : (pick < 6) ? 5'd0 : 5'($urandom);
      pick = $urandom_range(0, 9);
      rg = (pick < 4) ? 5'd0 : (pick < 6) ? 5'd25 : 5'($urandom);
      step($urandom_range(0, 9) != 0, phy, rg, 1'($urandom), 16'($urandom),
           1'($urandom), 1'($urandom), "");
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed_sink;
    seed_sink = $urandom(32'd20240611);

    // own address 0x13 with random traffic
    do_reset(5'h13);
    step(1, 5'h13, 5'd0, 0, 16'h0, 0, 0, "R4 default");
    step(1, 5'h00, 5'd25, 0, 16'h0, 1, 0, "R1 via zero addr");
    rand_run(200);

    // strapped zero forces isolate
    do_reset(5'h00);
    step(1, 5'h00, 5'd0, 1, 16'h0000, 0, 0, "R3 clear iso write");
    step(1, 5'h00, 5'd0, 0, 16'h0, 0, 0, "R3 iso readback");
    rand_run(100);

    // directed corner cases
    do_reset(5'h0D);
    step(1, 5'h0D, 5'd0, 1, 16'h0200, 0, 0, "R5 restart write");
    step(1, 5'h0D, 5'd0, 0, 16'h0, 0, 0, "R5 restart seen");
    step(1, 5'h0D, 5'd0, 0, 16'h0, 0, 0, "R5 restart cleared");
    step(1, 5'h0D, 5'd0, 1, 16'h0500, 0, 0, "R4 field write");
    step(1, 5'h0D, 5'd0, 0, 16'h0, 0, 0, "R4 field read");
    step(1, 5'h0D, 5'd0, 1, 16'hFFFF, 0, 0, "R6 reset write");
    step(1, 5'h0D, 5'd0, 0, 16'h0, 0, 0, "R6 reset seen");
    step(1, 5'h0D, 5'd0, 0, 16'h0, 0, 0, "R6 reset cleared");
    step(1, 5'h0D, 5'd25, 0, 16'h0, 1, 1, "R6 straps kept");
    step(1, 5'h0C, 5'd0, 1, 16'h0500, 0, 0, "R2 foreign write");
    step(1, 5'h0D, 5'd0, 0, 16'h0, 0, 0, "R2 foreign write ignored");
    step(1, 5'h0D, 5'd20, 1, 16'hFFFF, 0, 0, "R7 reserved write");
    step(1, 5'h0D, 5'd25, 1, 16'hFFFF, 0, 0, "R7 status write");
    step(1, 5'h0D, 5'd20, 0, 16'h0, 0, 0, "R7 reserved read");
    step(1, 5'h0D, 5'd25, 0, 16'h0, 0, 1, "R7 status unchanged");
    step(1, 5'h0D, 5'd0, 0, 16'h0, 0, 0, "R7 ctrl unchanged");
    step(0, 5'h0D, 5'd0, 0, 16'h0, 0, 0, "");

    // back-pressure: stalled response with a waiting request
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_phy = 5'h0D; req_reg = 5'd25; req_write = 1'b0;
    conn_ok = 1'b1; speed_10 = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R8 stall valid", rsp_valid, 1);
    chk("R8 stall ready", req_ready, 0);
    chk("R8 stall data", rsp_rdata, {9'h0, 1'b0, 1'b1, 5'h0D});
    req_reg = 5'd0;
    @(posedge clk); @(negedge clk);
    chk("R8 hold data", rsp_rdata, {9'h0, 1'b0, 1'b1, 5'h0D});
    chk("R8 hold valid", rsp_valid, 1);
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R8 next valid", rsp_valid, 1);
    chk("R8 next data", rsp_rdata, exp_read(5'd0, 1'b1, 1'b0));
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    pend = 1'b0;
    step(0, 5'h0D, 5'd0, 0, 16'h0, 0, 0, "");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule